// File: doc/BRIEF.md
# Frame-Boundary Stream Gate with Status Registers

This block sits in the path of a packetized video stream and either passes it through or holds it back. Both sides use a valid/ready handshake with start- and end-of-packet markers. When open, the gate joins the two sides with no register stage. Software opens the gate through a small word-addressed register port. When software asks it to close, the gate lets any frame already in progress run to its end, so a partial frame never reaches the stages after it.

While data flows, the block sorts each packet by the low nibble of its first beat into video, control and user packets. It tracks whether a frame is in progress, remembers that at least one frame has completed, and flags a frame whose pixel count does not match the expected size. It decodes the width, height and interlace nibble carried by control packets and makes them readable. It also holds a set of programmed frame parameters and drives them out to the stages that follow.

Top module: `vid_frame_gate`

## Requirements
- R1: After reset the run flag is 0, every status bit reads 0, `in_ready` and `out_valid` are low, and all `cfg_*` outputs are 0.
- R2: While the gate is open, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and data, `sop` and `eop` pass through unchanged in the same cycle. Writing 1 to bit 0 at word address 85 (control) sets the run flag from the next cycle.
- R3: The gate is open while the run flag is 1 or a frame is in progress. When the run flag is 0 outside a frame, `in_ready` and `out_valid` stay low. Writing 0 to the run flag during a frame lets that frame finish, including idle gaps between its packets, and then closes the gate.
- R4: A packet's kind comes from bits 3:0 of its first beat. 0x0 is video, 0xF is control, and any other value is user.
- R5: Status bit 0 (busy) goes to 1 on the accepted first beat of the first packet of a frame, whatever the kind of that packet. It goes back to 0 on the accepted last beat of a video packet.
- R6: Status bit 1 (done) goes to 1 on the accepted last beat of any video packet and then stays 1 until reset.
- R7: On the accepted last beat of a video packet, status bit 2 is set to 1 if the number of beats after the header differs from width times height, and to 0 if it matches. The size comes from the latest control packet once any control packet has arrived, and from the programmed width and height before that.
- R8: A control packet's beats after the header carry nibbles in bits 3:0. The first DIM_W/4 nibbles give the width, most significant nibble first. The next DIM_W/4 nibbles give the height in the same way, and the one after that is the interlace nibble. At the packet's last beat the decoded values become readable at word 82 (width), word 83 (height) and word 84 (interlace).
- R9: A read of word 2 returns the CONV_MODE parameter. A read of word 80 returns {err, done, busy} in bits 2:0 with zeros above. A read of any write-only or unmapped word returns 0.
- R10: `reg_rdvalid` is high in exactly the cycle after a cycle with `reg_read` high.
- R11: Writes to word 72 (width), word 73 (height), word 74 (interlace, 4 bits), word 76 (colour space, 2 bits: 0 RGB, 1 YCbCr, 2 mono) and word 77 (chroma, 2 bits: 0 for 4:2:0, 2 for 4:2:2, 3 for 4:4:4) appear on the matching `cfg_*` output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_write | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_read | input | 1 | Read request |
| reg_rdata | output | REG_W | Read data, valid with reg_rdvalid |
| reg_rdvalid | output | 1 | Read data valid, one cycle after the request |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat accepted |
| in_data | input | PIX_W | Upstream beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | PIX_W | Downstream beat data |
| out_sop | output | 1 | Downstream first beat |
| out_eop | output | 1 | Downstream last beat |
| cfg_width | output | DIM_W | Programmed frame width |
| cfg_height | output | DIM_W | Programmed frame height |
| cfg_interlace | output | 4 | Programmed interlace nibble |
| cfg_colour | output | 2 | Programmed colour space code |
| cfg_chroma | output | 2 | Programmed chroma sampling code |

## Verification
The hardest case to reach from the ports is a stop request that lands between two packets of the same frame. At that moment no beat is in flight, yet the gate must stay open until the video packet ends. The stimulus sends a control packet, writes 0 to the run flag, leaves the input idle for several cycles, and then sends the video packet. It expects every beat of that packet to pass and the next frame to be refused. Downstream backpressure on a repeating pattern runs through one whole frame, so that accepted beats and offered beats differ.

// File: rtl/vid_gate_pkg.sv
package vid_gate_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        KIND_VIDEO = 2'd0,
        KIND_CTRL  = 2'd1,
        KIND_USER  = 2'd2
    } pkt_kind_e;

    localparam logic [NIB_W-1:0] HDR_VIDEO = 4'h0;
    localparam logic [NIB_W-1:0] HDR_CTRL  = 4'hF;

    // register word addresses
    localparam int WA_MODE    = 2;
    localparam int WA_WIDTH   = 72;
    localparam int WA_HEIGHT  = 73;
    localparam int WA_ILACE   = 74;
    localparam int WA_COLOUR  = 76;
    localparam int WA_CHROMA  = 77;
    localparam int WA_STATUS  = 80;
    localparam int WA_CAP_W   = 82;
    localparam int WA_CAP_H   = 83;
    localparam int WA_CAP_IL  = 84;
    localparam int WA_CTRL    = 85;

    function automatic pkt_kind_e kind_of(input logic [NIB_W-1:0] nib);
        if (nib == HDR_VIDEO)     return KIND_VIDEO;
        else if (nib == HDR_CTRL) return KIND_CTRL;
        else                      return KIND_USER;
    endfunction

endpackage

// File: rtl/vg_gate.sv
module vg_gate (
    input  logic run,
    input  logic busy,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic fire
);
    logic open_w;

    always_comb begin
        open_w    = run | busy;
        in_ready  = out_ready & open_w;
        out_valid = in_valid & open_w;
        fire      = in_valid & out_ready & open_w;
    end
endmodule

// File: rtl/vg_pkt_tracker.sv
module vg_pkt_tracker
    import vid_gate_pkg::*;
#(
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             sop,
    input  logic             eop,
    input  logic [NIB_W-1:0] nib,
    input  logic [DIM_W-1:0] prog_w,
    input  logic [DIM_W-1:0] prog_h,
    output logic             busy,
    output logic             done,
    output logic             size_err,
    output logic [DIM_W-1:0] cap_w,
    output logic [DIM_W-1:0] cap_h,
    output logic [NIB_W-1:0] cap_il
);
    localparam int DIM_NIBS = DIM_W / NIB_W;
    localparam int CNT_W    = 2 * DIM_W;
    localparam int BEAT_W   = $clog2(2 * DIM_NIBS + 2);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             err;
        logic             ctrl_seen;
        pkt_kind_e        kind;
        logic [BEAT_W-1:0] beat;
        logic [CNT_W-1:0] pix;
        logic [DIM_W-1:0] sh_w;
        logic [DIM_W-1:0] sh_h;
        logic [NIB_W-1:0] sh_il;
        logic [DIM_W-1:0] cap_w;
        logic [DIM_W-1:0] cap_h;
        logic [NIB_W-1:0] cap_il;
    } trk_t;

    trk_t s_q, s_d;

    pkt_kind_e        kind_now;
    logic [CNT_W-1:0] expect_cnt;
    logic [CNT_W-1:0] pix_total;

    always_comb begin
        s_d      = s_q;
        kind_now = sop ? kind_of(nib) : s_q.kind;
        if (s_q.ctrl_seen)
            expect_cnt = {{DIM_W{1'b0}}, s_q.cap_w} * {{DIM_W{1'b0}}, s_q.cap_h};
        else
            expect_cnt = {{DIM_W{1'b0}}, prog_w} * {{DIM_W{1'b0}}, prog_h};
        pix_total = sop ? '0 : s_q.pix + 1'b1;

        if (fire) begin
            if (sop) begin
                s_d.kind  = kind_now;
                s_d.beat  = '0;
                s_d.pix   = '0;
                s_d.sh_w  = '0;
                s_d.sh_h  = '0;
                s_d.sh_il = '0;
                if (!s_q.busy) s_d.busy = 1'b1;
            end else begin
                case (s_q.kind)
                    KIND_VIDEO: s_d.pix = pix_total;
                    KIND_CTRL: begin
                        if (int'(s_q.beat) < DIM_NIBS)
                            s_d.sh_w = {s_q.sh_w[DIM_W-NIB_W-1:0], nib};
                        else if (int'(s_q.beat) < 2 * DIM_NIBS)
                            s_d.sh_h = {s_q.sh_h[DIM_W-NIB_W-1:0], nib};
                        else if (int'(s_q.beat) == 2 * DIM_NIBS)
                            s_d.sh_il = nib;
                        if (int'(s_q.beat) <= 2 * DIM_NIBS)
                            s_d.beat = s_q.beat + 1'b1;
                    end
                    default: ;
                endcase
            end

            if (eop) begin
                if (kind_now == KIND_CTRL) begin
                    s_d.cap_w     = s_d.sh_w;
                    s_d.cap_h     = s_d.sh_h;
                    s_d.cap_il    = s_d.sh_il;
                    s_d.ctrl_seen = 1'b1;
                end
                if (kind_now == KIND_VIDEO) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    s_d.err  = (pix_total != expect_cnt);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= KIND_USER;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign size_err = s_q.err;
    assign cap_w    = s_q.cap_w;
    assign cap_h    = s_q.cap_h;
    assign cap_il   = s_q.cap_il;
endmodule

// File: rtl/vg_regs.sv
module vg_regs
    import vid_gate_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int REG_W     = 32,
    parameter int DIM_W     = 16,
    parameter int CONV_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rd,
    input  logic              busy,
    input  logic              done,
    input  logic              size_err,
    input  logic [DIM_W-1:0]  cap_w,
    input  logic [DIM_W-1:0]  cap_h,
    input  logic [NIB_W-1:0]  cap_il,
    output logic [REG_W-1:0]  rdata,
    output logic              rdvalid,
    output logic              run,
    output logic [DIM_W-1:0]  cfg_w,
    output logic [DIM_W-1:0]  cfg_h,
    output logic [NIB_W-1:0]  cfg_il,
    output logic [1:0]        cfg_colour,
    output logic [1:0]        cfg_chroma
);
    localparam int STAT_W = 3;

    typedef struct packed {
        logic             run;
        logic [DIM_W-1:0] w;
        logic [DIM_W-1:0] h;
        logic [NIB_W-1:0] il;
        logic [1:0]       colour;
        logic [1:0]       chroma;
        logic             rdvalid;
        logic [REG_W-1:0] rdata;
    } reg_t;

    reg_t s_q, s_d;
    logic [REG_W-1:0] rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        case (addr)
            ADDR_W'(WA_MODE):   rd_mux = REG_W'(CONV_MODE);
            ADDR_W'(WA_STATUS): rd_mux = {{(REG_W-STAT_W){1'b0}}, size_err, done, busy};
            ADDR_W'(WA_CAP_W):  rd_mux = REG_W'(cap_w);
            ADDR_W'(WA_CAP_H):  rd_mux = REG_W'(cap_h);
            ADDR_W'(WA_CAP_IL): rd_mux = REG_W'(cap_il);
            default:            rd_mux = '0;
        endcase
    end

    always_comb begin
        s_d         = s_q;
        s_d.rdvalid = rd;
        s_d.rdata   = rd ? rd_mux : '0;
        if (wr) begin
            case (addr)
                ADDR_W'(WA_WIDTH):  s_d.w      = wdata[DIM_W-1:0];
                ADDR_W'(WA_HEIGHT): s_d.h      = wdata[DIM_W-1:0];
                ADDR_W'(WA_ILACE):  s_d.il     = wdata[NIB_W-1:0];
                ADDR_W'(WA_COLOUR): s_d.colour = wdata[1:0];
                ADDR_W'(WA_CHROMA): s_d.chroma = wdata[1:0];
                ADDR_W'(WA_CTRL):   s_d.run    = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata      = s_q.rdata;
    assign rdvalid    = s_q.rdvalid;
    assign run        = s_q.run;
    assign cfg_w      = s_q.w;
    assign cfg_h      = s_q.h;
    assign cfg_il     = s_q.il;
    assign cfg_colour = s_q.colour;
    assign cfg_chroma = s_q.chroma;
endmodule

// File: rtl/vid_frame_gate.sv
module vid_frame_gate
    import vid_gate_pkg::*;
#(
    parameter int PIX_W     = 24,
    parameter int DIM_W     = 16,
    parameter int ADDR_W    = 7,
    parameter int REG_W     = 32,
    parameter int CONV_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_write,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_read,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_rdvalid,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DIM_W-1:0]  cfg_width,
    output logic [DIM_W-1:0]  cfg_height,
    output logic [3:0]        cfg_interlace,
    output logic [1:0]        cfg_colour,
    output logic [1:0]        cfg_chroma
);
    logic             run_w, busy_w, done_w, err_w, fire_w;
    logic [DIM_W-1:0] cap_w_w, cap_h_w;
    logic [NIB_W-1:0] cap_il_w;

    assign out_data = in_data;
    assign out_sop  = in_sop;
    assign out_eop  = in_eop;

    vg_gate u_gate (
        .run       (run_w),
        .busy      (busy_w),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .fire      (fire_w)
    );

    vg_pkt_tracker #(.DIM_W(DIM_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire_w),
        .sop      (in_sop),
        .eop      (in_eop),
        .nib      (in_data[NIB_W-1:0]),
        .prog_w   (cfg_width),
        .prog_h   (cfg_height),
        .busy     (busy_w),
        .done     (done_w),
        .size_err (err_w),
        .cap_w    (cap_w_w),
        .cap_h    (cap_h_w),
        .cap_il   (cap_il_w)
    );

    vg_regs #(
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .DIM_W     (DIM_W),
        .CONV_MODE (CONV_MODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr         (reg_write),
        .wdata      (reg_wdata),
        .rd         (reg_read),
        .busy       (busy_w),
        .done       (done_w),
        .size_err   (err_w),
        .cap_w      (cap_w_w),
        .cap_h      (cap_h_w),
        .cap_il     (cap_il_w),
        .rdata      (reg_rdata),
        .rdvalid    (reg_rdvalid),
        .run        (run_w),
        .cfg_w      (cfg_width),
        .cfg_h      (cfg_height),
        .cfg_il     (cfg_interlace),
        .cfg_colour (cfg_colour),
        .cfg_chroma (cfg_chroma)
    );
endmodule

// File: rtl/vid_frame_gate_chk.sv
module vid_frame_gate_chk
    import vid_gate_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_write,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              reg_read,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              reg_rdvalid,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sop,
    input logic              in_eop,
    input logic              out_valid,
    input logic              run,
    input logic              busy,
    input logic              done
);
    assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !busy) |-> (!in_ready && !out_valid));

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_write && reg_addr == ADDR_W'(WA_CTRL) && reg_wdata[0]) |=> run);

    assert_busy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sop && !in_eop && !busy) |=> busy);

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_status_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_read && reg_addr == ADDR_W'(WA_STATUS)) |=> (reg_rdata[REG_W-1:3] == '0));

    assert_wo_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_read && reg_addr == ADDR_W'(WA_CTRL)) |=> (reg_rdata == '0));

    assert_rdvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_read |=> reg_rdvalid);

    assert_no_rdvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_read |=> !reg_rdvalid);
endmodule

bind vid_frame_gate vid_frame_gate_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_write   (reg_write),
    .reg_wdata   (reg_wdata),
    .reg_read    (reg_read),
    .reg_rdata   (reg_rdata),
    .reg_rdvalid (reg_rdvalid),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sop      (in_sop),
    .in_eop      (in_eop),
    .out_valid   (out_valid),
    .run         (run_w),
    .busy        (busy_w),
    .done        (done_w)
);

// File: tb/vid_frame_gate_test.sv
module vid_frame_gate_test;
    localparam int PIX_W = 24, DIM_W = 16, ADDR_W = 7, REG_W = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic [ADDR_W-1:0] reg_addr;
    logic              reg_write, reg_read;
    logic [REG_W-1:0]  reg_wdata, reg_rdata;
    logic              reg_rdvalid;
    logic              in_valid, in_ready, in_sop, in_eop;
    logic [PIX_W-1:0]  in_data, out_data;
    logic              out_valid, out_ready, out_sop, out_eop;
    logic [DIM_W-1:0]  cfg_width, cfg_height;
    logic [3:0]        cfg_interlace;
    logic [1:0]        cfg_colour, cfg_chroma;

    vid_frame_gate uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_write(reg_write), .reg_wdata(reg_wdata),
        .reg_read(reg_read), .reg_rdata(reg_rdata), .reg_rdvalid(reg_rdvalid),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_interlace(cfg_interlace),
        .cfg_colour(cfg_colour), .cfg_chroma(cfg_chroma)
    );

    int  n_tests = 0, n_fail = 0;
    bit  finished = 0;

    // behavioural reference state
    bit     m_run, m_busy, m_done, m_err, m_seen;
    int     m_kind, m_pix;
    int     q_nib[$];
    longint m_capw, m_caph, m_capil;
    longint m_pw, m_ph, m_pil, m_col, m_chr;
    bit     bp_en = 0;
    int     cyc = 0;
    bit     last_fire;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint model_read(input int a);
        case (a)
            2:  return 0;
            80: return {61'd0, m_err, m_done, m_busy};
            82: return m_capw;
            83: return m_caph;
            84: return m_capil;
            default: return 0;
        endcase
    endfunction

    function automatic string read_tag(input int a);
        case (a)
            80: return "R5/R6/R7 status read";
            82, 83, 84: return "R8 captured read";
            2:  return "R9 mode read";
            default: return "R9 zero read";
        endcase
    endfunction

    task automatic model_beat(input int nib, input bit s, input bit e);
        longint expect_n;
        if (s) begin
            m_kind = (nib == 0) ? 0 : (nib == 15) ? 1 : 2;   // R4
            m_pix  = 0;
            q_nib.delete();
            m_busy = 1;
        end else begin
            if (m_kind == 0) m_pix++;
            else if (m_kind == 1) q_nib.push_back(nib);
        end
        if (e) begin
            if (m_kind == 1) begin
                m_capw = 0; m_caph = 0; m_capil = 0;
                for (int i = 0; i < 4; i++) if (i < q_nib.size()) m_capw = m_capw * 16 + q_nib[i];
                for (int i = 4; i < 8; i++) if (i < q_nib.size()) m_caph = m_caph * 16 + q_nib[i];
                if (q_nib.size() > 8) m_capil = q_nib[8];
                m_seen = 1;
            end else if (m_kind == 0) begin
                expect_n = m_seen ? m_capw * m_caph : m_pw * m_ph;
                m_busy = 0;
                m_done = 1;
                m_err  = (m_pix != expect_n);
            end
        end
    endtask

    task automatic model_write(input int a, input logic [31:0] d);
        case (a)
            72: m_pw  = d[15:0];
            73: m_ph  = d[15:0];
            74: m_pil = d[3:0];
            76: m_col = d[1:0];
            77: m_chr = d[1:0];
            85: m_run = d[0];
            default: ;
        endcase
    endtask

    task automatic tick();
        bit     open_e, fire, nrdv;
        longint nrd;
        string  tg;
        if (bp_en) out_ready = (cyc % 3 != 1);
        cyc++;
        #1;
        open_e = m_run || m_busy;
        check(in_ready == (out_ready && open_e), "R3 in_ready", in_ready, out_ready && open_e);
        check(out_valid == (in_valid && open_e), "R2/R3 out_valid", out_valid, in_valid && open_e);
        if (out_valid)
            check({out_data, out_sop, out_eop} == {in_data, in_sop, in_eop}, "R2 passthrough",
                  {out_data, out_sop, out_eop}, {in_data, in_sop, in_eop});
        fire = in_valid && out_ready && open_e;
        last_fire = fire;
        nrdv = reg_read;
        nrd  = reg_read ? model_read(int'(reg_addr)) : 0;
        tg   = read_tag(int'(reg_addr));
        if (fire) model_beat(int'(in_data[3:0]), in_sop, in_eop);
        if (reg_write) model_write(int'(reg_addr), reg_wdata);
        @(negedge clk);
        check(reg_rdvalid == nrdv, "R10 rdvalid", reg_rdvalid, nrdv);
        if (nrdv) check(reg_rdata == nrd[31:0], tg, reg_rdata, nrd);
        check({cfg_width, cfg_height, cfg_interlace, cfg_colour, cfg_chroma} ==
              {m_pw[15:0], m_ph[15:0], m_pil[3:0], m_col[1:0], m_chr[1:0]}, "R11 cfg outputs",
              {cfg_width, cfg_height, cfg_interlace, cfg_colour, cfg_chroma},
              {m_pw[15:0], m_ph[15:0], m_pil[3:0], m_col[1:0], m_chr[1:0]});
    endtask

    task automatic write_reg(input int a, input logic [31:0] d);
        reg_write = 1; reg_addr = ADDR_W'(a); reg_wdata = d;
        tick();
        reg_write = 0; reg_wdata = '0;
    endtask

    task automatic read_reg(input int a);
        reg_read = 1; reg_addr = ADDR_W'(a);
        tick();
        reg_read = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send_beat(input logic [PIX_W-1:0] d, input bit s, input bit e);
        int guard = 0;
        in_valid = 1; in_data = d; in_sop = s; in_eop = e;
        do begin tick(); guard++; end while (!last_fire && guard < 200);
        check(last_fire, "R2 beat accepted", last_fire, 1);
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic offer_blocked(input int n);
        in_valid = 1; in_data = 24'h770000; in_sop = 1; in_eop = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            check(!last_fire, "R3 blocked at boundary", last_fire, 0);
        end
        in_valid = 0; in_sop = 0;
    endtask

    task automatic send_ctrl(input int w, input int h, input int il);
        send_beat(24'h3C000F, 1, 0);
        for (int i = 0; i < 4; i++) send_beat({8'h5A, 12'h0, 4'((w >> (12 - 4 * i)) & 15)}, 0, 0);
        for (int i = 0; i < 4; i++) send_beat({8'hA5, 12'h0, 4'((h >> (12 - 4 * i)) & 15)}, 0, 0);
        send_beat({8'h11, 12'h0, 4'(il)}, 0, 1);
    endtask

    task automatic send_video(input int n);
        if (n == 0) begin
            send_beat(24'hC30000, 1, 1);
        end else begin
            send_beat(24'hC30000, 1, 0);
            for (int i = 0; i < n; i++) send_beat(PIX_W'(24'h100000 + i * 7), 0, i == n - 1);
        end
    endtask

    task automatic send_user(input int len);
        send_beat(24'h000003, 1, len == 0);
        for (int i = 0; i < len; i++) send_beat(PIX_W'(24'h200000 + i), 0, i == len - 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; reg_addr = '0; reg_write = 0; reg_wdata = '0; reg_read = 0;
        in_valid = 0; in_data = '0; in_sop = 0; in_eop = 0; out_ready = 1;
        m_run = 0; m_busy = 0; m_done = 0; m_err = 0; m_seen = 0; m_kind = 2; m_pix = 0;
        m_capw = 0; m_caph = 0; m_capil = 0; m_pw = 0; m_ph = 0; m_pil = 0; m_col = 0; m_chr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state at the ports
        in_valid = 1; in_sop = 1; #1;
        check(!in_ready && !out_valid, "R1 reset gate closed", {in_ready, out_valid}, 0);
        check(cfg_width == 0 && cfg_height == 0 && cfg_colour == 0, "R1 reset cfg", cfg_width, 0);
        in_valid = 0; in_sop = 0;
        @(negedge clk);
        read_reg(80); read_reg(2); read_reg(82); read_reg(85); read_reg(100);

        // R3: stopped at boundary blocks packets
        offer_blocked(4);

        // R11 programming
        write_reg(72, 32'hFFFF0004); write_reg(73, 2); write_reg(74, 5);
        write_reg(76, 2); write_reg(77, 3);
        write_reg(85, 1);                       // R2 start

        // R5/R6/R7: exact size from programmed 4x2
        send_video(8); read_reg(80);
        // R4 user packet opens frame, short video -> error
        send_user(3); idle(1); read_reg(80);
        send_video(7); read_reg(80);

        // R8 capture under backpressure
        bp_en = 1;
        send_ctrl(3, 2, 10); send_user(2); send_video(6);
        bp_en = 0; out_ready = 1;
        read_reg(80); read_reg(82); read_reg(83); read_reg(84);

        // R3 stop between packets of a frame: frame completes
        send_ctrl(5, 1, 3);
        write_reg(85, 0);
        idle(3);
        send_video(5);
        read_reg(80);
        offer_blocked(3);

        // R3 stop while idle: immediate
        write_reg(85, 1); write_reg(85, 0);
        offer_blocked(3);

        // R7 header-only video against 5x1
        write_reg(85, 1);
        send_video(0); read_reg(80);
        // R7 oversize
        send_video(9); read_reg(80);

        // R9 write-only and unmapped reads
        read_reg(85); read_reg(72); read_reg(127);
        idle(2);
        finish_run();
    end
endmodule